// File: doc/BRIEF.md
# Serial SAR-ADC Read Controller

This block runs the host side of a 12-bit successive-approximation converter that has a serial output. Each frame begins when the block drops the active-low select line. That edge sets the instant at which the converter samples its input. The block then drives a serial clock, derived from the system clock, for exactly 16 cycles. During those cycles it shifts in one bit per cycle from the converter's data line. The first four bits of the word are fixed zeros. The remaining twelve bits form an unsigned, straight-binary sample, sent most significant bit first. The block strips the four zeros and presents the twelve data bits with a one-cycle valid strobe.

Software or a sequencer sets the serial clock rate through a half-period divider given in system clock cycles. A floor clamps the divider so that the serial clock cannot run faster than the converter allows. Between frames the block keeps the select line high for at least a fixed quiet time. A start request that arrives while a frame or a quiet gap is running is remembered and served as soon as the block returns to idle. Holding the request high therefore produces a steady stream of conversions, with the sampling rate set by the divider.

Top module: `sarReadCtrl`

## Requirements
- R1: After reset, csN and sclk are 1 and busy, sampleValid, sample and protoErr are 0.
- R2: csN falls on the first clock edge at which startReq (or a held request) is seen while idle. sclk is high when csN falls, and its first falling edge comes exactly H system cycles later. H is the effective half period.
- R3: H equals divIn, or MIN_HALF (13) when divIn is smaller. While csN is low, sclk makes exactly 16 falling edges and every high or low phase lasts H cycles. The last high phase lasts H cycles before csN rises, so csN stays low for 33·H cycles.
- R4: The converter changes sdata after each sclk falling edge. The block samples sdata in the cycle in which sclk goes high again. The first sampled bit is the first bit of the word, bits arrive MSB first, and sample equals the last 12 bits unchanged.
- R5: sampleValid is a single-cycle pulse in the same cycle that csN rises. sample and protoErr hold their values until the next pulse.
- R6: protoErr is 1 together with the delivered sample when any of the first 4 bits of the frame was 1. The sample is still delivered.
- R7: After csN rises, it stays high for at least QUIET_CYC+1 (16) cycles before it falls again.
- R8: A startReq seen during a frame or during the quiet gap is held pending. The next frame's csN fall comes exactly QUIET_CYC+1 cycles after the previous csN rise. If startReq is held high, frames repeat back to back with that gap.
- R9: divIn is taken in only while idle. A change of divIn during a frame leaves that frame's phase lengths unchanged.
- R10: busy is 1 from the cycle after a frame starts until QUIET_CYC cycles after csN rises, and is 0 from then until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request for one conversion frame |
| divIn | input | DIV_W (8) | Serial clock half period in system cycles, floored at MIN_HALF |
| sdata | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low select; its falling edge is the sampling instant |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or quiet gap in progress |
| sample | output | 12 | Last delivered unsigned sample |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| protoErr | output | 1 | A leading bit of the last frame was 1 |

## Verification
The assertions assume that rstN is released synchronously to clk. They also assume that divIn and startReq change only between clock edges, so the counters in the checker see a single clean edge of csN and sclk. The stimulus meets this by driving every input one nanosecond after a rising clock edge, with divIn kept inside its 8-bit range. The converter model changes sdata only shortly after each sclk fall, so every sampled bit is stable for a whole phase.

// File: rtl/sarReadPkg.sv
package sarReadPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_QUIET
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // new frame: empty the shift register
    logic shiftEn;  // take one bit from sdata
    logic deliver;  // publish sample and error flag
  } pathStrobe_t;

endpackage

// File: rtl/sarCtrlFsm.sv
module sarCtrlFsm
  import sarReadPkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int MIN_HALF   = 13,
  parameter int QUIET_CYC  = 15,
  parameter int FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] divIn,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output pathStrobe_t      strobe
);

  localparam int QW    = $clog2(QUIET_CYC + 1);
  localparam int CNT_W = (DIV_W > QW) ? DIV_W : QW;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] edgeIdx;
  logic [DIV_W-1:0] halfReg;
  logic [DIV_W-1:0] halfNow;
  logic [CNT_W-1:0] halfLoad;
  logic [CNT_W-1:0] halfLoadNow;
  logic             pending;
  logic             goNow;
  logic             cntZero;

  always_comb begin
    halfNow     = (divIn < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : divIn;
    halfLoad    = CNT_W'(halfReg) - CNT_W'(1);
    halfLoadNow = CNT_W'(halfNow) - CNT_W'(1);
    cntZero     = (cnt == '0);
    goNow       = (state == ST_IDLE) && (startReq || pending);
    busy        = (state != ST_IDLE);
  end

  always_comb begin
    strobe.clear   = goNow;
    strobe.shiftEn = (state == ST_SHIFT) && cntZero && !sclk;
    strobe.deliver = (state == ST_HOLD) && cntZero;
  end

  // divider is sampled only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfReg <= DIV_W'(MIN_HALF);
    end else if (state == ST_IDLE) begin
      halfReg <= halfNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (goNow) begin
      pending <= 1'b0;
    end else if (startReq && (state != ST_IDLE)) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      edgeIdx <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (goNow) begin
            state <= ST_SETUP;
            csN   <= 1'b0;
            cnt   <= halfLoadNow;
          end
        end
        ST_SETUP: begin
          if (cntZero) begin
            state   <= ST_SHIFT;
            sclk    <= 1'b0;
            edgeIdx <= '0;
            cnt     <= halfLoad;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (cntZero) begin
            cnt <= halfLoad;
            if (!sclk) begin
              sclk <= 1'b1;
              if (edgeIdx == LAST_IDX) begin
                state <= ST_HOLD;
              end
            end else begin
              sclk    <= 1'b0;
              edgeIdx <= edgeIdx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cntZero) begin
            state <= ST_QUIET;
            csN   <= 1'b1;
            cnt   <= CNT_W'(QUIET_CYC - 1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_QUIET: begin
          if (cntZero) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sarShiftPath.sv
module sarShiftPath
  import sarReadPkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SAMPLE_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pathStrobe_t            strobe,
  input  logic                   sdata,
  output logic [SAMPLE_BITS-1:0] sample,
  output logic                   sampleValid,
  output logic                   protoErr
);

  localparam int LEAD_BITS = FRAME_BITS - SAMPLE_BITS;

  logic [FRAME_BITS-1:0] shiftReg;
  logic                  leadHigh;

  always_comb leadHigh = |shiftReg[FRAME_BITS-1 -: LEAD_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clear) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sample      <= '0;
      protoErr    <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.deliver;
      if (strobe.deliver) begin
        sample   <= shiftReg[SAMPLE_BITS-1:0];
        protoErr <= leadHigh;
      end
    end
  end

endmodule

// File: rtl/sarReadCtrl.sv
module sarReadCtrl
  import sarReadPkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MIN_HALF    = 13,
  parameter int QUIET_CYC   = 15,
  parameter int FRAME_BITS  = 16,
  parameter int SAMPLE_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [DIV_W-1:0]       divIn,
  input  logic                   sdata,
  output logic                   csN,
  output logic                   sclk,
  output logic                   busy,
  output logic [SAMPLE_BITS-1:0] sample,
  output logic                   sampleValid,
  output logic                   protoErr
);

  pathStrobe_t strobe;

  sarCtrlFsm #(
    .DIV_W     (DIV_W),
    .MIN_HALF  (MIN_HALF),
    .QUIET_CYC (QUIET_CYC),
    .FRAME_BITS(FRAME_BITS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .divIn   (divIn),
    .csN     (csN),
    .sclk    (sclk),
    .busy    (busy),
    .strobe  (strobe)
  );

  sarShiftPath #(
    .FRAME_BITS (FRAME_BITS),
    .SAMPLE_BITS(SAMPLE_BITS)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sdata      (sdata),
    .sample     (sample),
    .sampleValid(sampleValid),
    .protoErr   (protoErr)
  );

endmodule

// File: rtl/sarReadCtrlChk.sv
module sarReadCtrlChk #(
  parameter int QUIET_CYC  = 15,
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic busy,
  input logic sampleValid
);

  localparam int QLIM = QUIET_CYC + 1;
  localparam int QC_W = $clog2(QLIM + 1) + 1;
  localparam int FC_W = $clog2(FRAME_BITS + 1) + 1;

  logic            prevCs;
  logic            prevSclk;
  logic [QC_W-1:0] quietCnt;
  logic [FC_W-1:0] fallCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b1;
      quietCnt <= QC_W'(QLIM);
      fallCnt  <= '0;
    end else begin
      prevCs   <= csN;
      prevSclk <= sclk;
      if (!csN) begin
        quietCnt <= '0;
      end else if (quietCnt < QC_W'(QLIM)) begin
        quietCnt <= quietCnt + QC_W'(1);
      end
      if (!csN && prevCs) begin
        fallCnt <= '0;
      end else if (!csN && prevSclk && !sclk) begin
        fallCnt <= fallCnt + FC_W'(1);
      end
    end
  end

  // R2: select falls only while the serial clock idles high
  assert_sclk_high_at_cs_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && prevCs) |-> sclk);

  // R3: serial clock stays high while deselected
  assert_sclk_idle_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R3: exactly FRAME_BITS falling edges per frame
  assert_frame_fall_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !prevCs) |-> (fallCnt == FC_W'(FRAME_BITS)));

  // R5: valid strobe coincides with the select rising
  assert_valid_at_cs_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (csN && !prevCs));

  assert_cs_rise_gives_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !prevCs) |-> sampleValid);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R7: minimum quiet gap before the next frame
  assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && prevCs) |-> (quietCnt >= QC_W'(QLIM)));

  // R10: busy covers every selected cycle
  assert_busy_in_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

endmodule

bind sarReadCtrl sarReadCtrlChk #(
  .QUIET_CYC (QUIET_CYC),
  .FRAME_BITS(FRAME_BITS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .sclk       (sclk),
  .busy       (busy),
  .sampleValid(sampleValid)
);

// File: tb/sarReadCtrl_tb_top.sv
`timescale 1ns/1ps
module sarReadCtrl_tb_top;

  localparam int MINH = 13;
  localparam int QC   = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  divIn = 8'd0;
  logic        sdata = 1'b0;
  logic        csN;
  logic        sclk;
  logic        busy;
  logic [11:0] sample;
  logic        sampleValid;
  logic        protoErr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sarReadCtrl dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .divIn(divIn), .sdata(sdata),
    .csN(csN), .sclk(sclk), .busy(busy), .sample(sample),
    .sampleValid(sampleValid), .protoErr(protoErr)
  );

  // converter model: next bit appears shortly after each sclk fall
  logic [15:0] txWord = 16'h0;
  int txIdx = 0;
  always @(negedge csN) txIdx = 0;
  always @(negedge sclk) begin
    if (!csN && txIdx < 16) begin
      #1;
      sdata = txWord[15 - txIdx];
      txIdx++;
    end
  end

  // monitor of edge timing
  int cyc = 0;
  int csFallCyc = 0, firstFall = -1, nFalls = 0, lastEdge = 0, phaseBad = 0;
  int csRiseCyc = -1, validCyc = -1, validCnt = 0, lastGap = -1;
  int expH = MINH;
  logic prevCs = 1'b1, prevSclk = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevCs && !csN) begin
        if (csRiseCyc >= 0) lastGap = cyc - csRiseCyc;
        csFallCyc = cyc; nFalls = 0; lastEdge = cyc; phaseBad = 0; firstFall = -1;
      end else if (!csN && sclk != prevSclk) begin
        if (cyc - lastEdge != expH) phaseBad++;
        lastEdge = cyc;
        if (!sclk) begin
          nFalls++;
          if (firstFall < 0) firstFall = cyc;
        end
      end else if (!prevCs && csN) begin
        if (cyc - lastEdge != expH) phaseBad++;
        csRiseCyc = cyc;
      end
      if (sampleValid) begin
        validCyc = cyc;
        validCnt++;
      end
    end
    prevCs = csN;
    prevSclk = sclk;
  end

  task automatic check(input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int effHalf(input int d);
    return (d < MINH) ? MINH : d;
  endfunction

  function automatic int expErr(input logic [15:0] w);
    return (w[15:12] != 4'h0) ? 1 : 0;
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitIdle();
    while (busy) tick();
  endtask

  task automatic waitValid();
    int v0 = validCnt;
    while (validCnt == v0) tick();
  endtask

  task automatic startFrame(input logic [15:0] w, input int d);
    waitIdle();
    txWord = w;
    divIn = 8'(d);
    expH = effHalf(d);
    @(posedge clk); #1;
    startReq = 1'b1;
    check(int'(csN), 1, "R2 select high before start edge");
    @(posedge clk); #1;
    startReq = 1'b0;
    check(int'(csN), 0, "R2 select low after start edge");
    check(int'(busy), 1, "R10 busy after start");
  endtask

  task automatic checkFrame(input logic [15:0] w);
    check(firstFall - csFallCyc, expH, "R2 select-to-first-fall");
    check(nFalls, 16, "R3 falling edge count");
    check(phaseBad, 0, "R3 phase length errors");
    check(csRiseCyc - csFallCyc, 33 * expH, "R3 select low length");
    check(int'(sample), int'(w[11:0]), "R4 sample value");
    check(int'(protoErr), expErr(w), "R6 leading-bit error flag");
    check(validCyc, csRiseCyc, "R5 valid at select rise");
  endtask

  task automatic checkTail(input logic [15:0] w);
    tick();
    check(int'(sampleValid), 0, "R5 valid is one cycle");
    check(int'(sample), int'(w[11:0]), "R5 sample holds");
    repeat (QC - 2) tick();
    check(int'(busy), 1, "R10 busy through quiet gap");
    tick();
    check(int'(busy), 0, "R10 busy clears after quiet gap");
  endtask

  task automatic fullFrame(input logic [15:0] w, input int d);
    startFrame(w, d);
    waitValid();
    checkFrame(w);
    checkTail(w);
  endtask

  // watchdog
  initial begin
    while (cyc < 190000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int d;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    // R1 reset state, checked while reset is asserted and just after release
    check(int'(csN), 1, "R1 csN reset");
    check(int'(sclk), 1, "R1 sclk reset");
    check(int'(busy), 0, "R1 busy reset");
    check(int'(sampleValid), 0, "R1 valid reset");
    check(int'(sample), 0, "R1 sample reset");
    check(int'(protoErr), 0, "R1 error reset");
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (4) tick();
    check(int'(csN), 1, "R1 idle without request");

    // directed patterns
    fullFrame(16'h0FFF, 0);   // divider below floor -> clamped
    fullFrame(16'h0000, 20);
    fullFrame(16'h0800, 13);
    fullFrame(16'h0001, 14);
    fullFrame(16'hF555, 16);  // R6 error flag with data
    fullFrame(16'h1ABC, 13);  // R6 single leading bit set
    fullFrame(16'h0A5A, 12);  // just below floor

    // R9 divider changed mid-frame has no effect on current frame
    startFrame(16'h0321, 15);
    repeat (40) tick();
    divIn = 8'd30;
    waitValid();
    checkFrame(16'h0321);
    checkTail(16'h0321);
    // divider taken up once idle
    fullFrame(16'h0456, 30);

    // R8 request during a frame is held and served after the quiet gap
    startFrame(16'h0111, 14);
    repeat (100) tick();
    @(posedge clk); #1; startReq = 1'b1;
    @(posedge clk); #1; startReq = 1'b0;
    waitValid();
    checkFrame(16'h0111);
    txWord = 16'h0EEE;
    waitValid();
    checkFrame(16'h0EEE);
    check(lastGap, QC + 1, "R8 pending start gap");
    checkTail(16'h0EEE);

    // R8 / R7 held request gives back-to-back frames
    waitIdle();
    divIn = 8'd13;
    expH = 13;
    txWord = 16'h0C3C;
    @(posedge clk); #1; startReq = 1'b1;
    waitValid();
    checkFrame(16'h0C3C);
    for (int k = 0; k < 2; k++) begin
      txWord = 16'h0100 + 16'(k);
      waitValid();
      checkFrame(16'h0100 + 16'(k));
      check(lastGap, QC + 1, "R7 back-to-back quiet gap");
    end
    startReq = 1'b0;
    txWord = 16'h0777;
    waitValid();
    checkFrame(16'h0777);
    checkTail(16'h0777);

    // constrained random
    for (int n = 0; n < 20; n++) begin
      w = 16'($urandom);
      if (($urandom % 4) != 0) w[15:12] = 4'h0;
      d = int'($urandom % 40);
      fullFrame(w, d);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule